// File: doc/BRIEF.md
# CPU-Paced I2C Byte Master

This block is a single-master I2C engine that software steps through a transfer one byte at a time. The processor sees two registers: a control/status register and a data register. To begin a transfer, software sets a start request and then writes the target's 7-bit address together with the direction bit into the data register. The block then drives a start condition followed by that byte. After each byte, including its ninth (acknowledge) clock, the block raises a completion flag, records whether the target acknowledged, and emits a one-cycle interrupt pulse.

On a write, every further byte written to the data register is shifted out after the previous one. On a read, each read of the data register returns the most recently received byte and also starts reception of the next one. When software sets the last-read bit before the final byte, the block answers that byte with a NAK. A stop request holds its flag high until the stop condition has been sent on the bus, and the flag then reads back low.

The block drives SCL and SDA through open-drain pull-down outputs and reads SDA back. If SDA reads back at a level different from the one the block is driving, the block sets a bus-error flag. Software writes the data register only while the block is idle, and it waits for the stop flag to clear before touching the data register again. Slave mode, clock stretching by targets, recovery from arbitration loss and 10-bit addressing are not part of this block.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, both bus pull-downs are off, the status register reads 0x00 and irq is low.
- R2: With a start request pending, a write to the data register (reg_sel=1) produces a start condition (SDA falling while SCL is high) and then shifts out the written byte most significant bit first. The start request is set by bit 7 of a control write (reg_sel=0).
- R3: At the end of the ninth clock of each byte, status bit 0 (DONE) is set. In the same update, status bit 1 (ACK) records 1 if SDA was low during that ninth clock and 0 if it was high.
- R4: irq is high for exactly one clock cycle each time DONE goes from 0 to 1.
- R5: Any read or write of the data register clears DONE.
- R6: A data-register write made while the engine is idle and no start request is pending sends the byte with no start condition in front of it.
- R7: After an address byte whose bit 0 is 1, each read of the data register returns the last received byte and starts reception of the next one. The block drives ACK (SDA low) on the ninth clock of every received byte, except when the last-read bit (control bit 5) is set, in which case it leaves SDA released (NAK). Once a NAK'd byte has been received, a data read starts no further reception.
- R8: A control write with bit 6 set requests a stop. Status bit 6 reads 1 until the stop condition (SDA rising while SCL is high) has been driven. It then reads 0, with both pull-downs off.
- R9: Status bit 2 (BERR) is set when SDA is sampled at a level other than the one the block drives during a bit the block owns. A control write that sets the start request clears BERR.
- R10: Data-register writes are ignored while a byte or bus condition is in progress or while a stop request is pending.
- R11: Each SCL high phase lasts 2*QTR_CLKS clocks (a bit is 4*QTR_CLKS clocks). While the engine is idle, SCL does not change.
- R12: A start request followed by an address write while the bus is still held (no stop in between) produces a repeated start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | 0 selects control/status, 1 selects data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data read has side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | One-cycle pulse on each byte completion |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
The bench attaches a behavioural target to the open-drain lines. It targets the following failure modes:
- A NAK on the address: a design that captured ACK with inverted sense, or on the wrong clock, would report the wrong acknowledge.
- The final byte of a read: a design that ignored the last-read bit would ACK it, and a design that kept reading after the NAK would toggle SCL again when software collects the final byte.
- Writes made while a byte is in progress or while a stop is pending: a design that accepted them would emit extra bytes on the bus.
- A forced contention on SDA, followed by a repeated start: these expose a missing or sticky bus-error flag and a start that needs an idle bus.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int QTR_CLKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       scl_pull,
  output logic       sda_pull,
  input  logic       sda_in
);
  localparam int CW = (QTR_CLKS > 1) ? $clog2(QTR_CLKS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] div;
  logic [1:0]    qtr;
  logic [3:0]    bitn;
  logic [7:0]    tx_sh, rx_sh;
  logic          scl_low, sda_low;
  logic          start_req, stop_req, lastrd;
  logic          done, done_q, ack, berr;
  logic          rd_mode, cur_rd, addr_byte;

  function automatic logic sda_for(input logic [3:0] n, input logic rd,
                                   input logic lr, input logic [7:0] sh);
    if (rd) return (n == 4'd8) && !lr;
    return (n < 4'd8) && !sh[3'd7 - n[2:0]];
  endfunction

  wire tick        = (st != S_IDLE) && (div == CW'(QTR_CLKS - 1));
  wire data_acc    = (reg_wr | reg_rd) & reg_sel;
  wire ctrl_wr     = reg_wr & ~reg_sel;
  wire launch_wr   = reg_wr & reg_sel & (st == S_IDLE) & ~stop_req;
  wire launch_rd   = reg_rd & reg_sel & (st == S_IDLE) & ~stop_req & rd_mode & ~start_req;
  wire launch_stop = (st == S_IDLE) & stop_req;
  wire owns_bit    = cur_rd ? (bitn == 4'd8) : (bitn < 4'd8);

  assign scl_pull = scl_low;
  assign sda_pull = sda_low;
  assign rdata    = reg_sel ? rx_sh : {start_req, stop_req, lastrd, 2'b00, berr, ack, done};
  assign irq      = done & ~done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; div <= '0; qtr <= 2'd0; bitn <= 4'd0;
      tx_sh <= 8'h00; rx_sh <= 8'h00;
      scl_low <= 1'b0; sda_low <= 1'b0;
      start_req <= 1'b0; stop_req <= 1'b0; lastrd <= 1'b0;
      done <= 1'b0; done_q <= 1'b0; ack <= 1'b0; berr <= 1'b0;
      rd_mode <= 1'b0; cur_rd <= 1'b0; addr_byte <= 1'b0;
    end else begin
      done_q <= done;
      div    <= (st == S_IDLE || tick) ? '0 : div + 1'b1;
      if (tick) qtr <= qtr + 2'd1;

      if (ctrl_wr) begin
        if (wdata[7]) begin start_req <= 1'b1; berr <= 1'b0; end
        if (wdata[6]) stop_req <= 1'b1;
        lastrd <= wdata[5];
      end
      if (data_acc) done <= 1'b0;

      case (st)
        S_IDLE: begin
          qtr  <= 2'd0;
          bitn <= 4'd0;
          if (launch_wr) begin
            tx_sh     <= wdata;
            cur_rd    <= 1'b0;
            addr_byte <= start_req;
            if (start_req) begin
              st      <= S_START;
              sda_low <= 1'b0;
            end else begin
              st      <= S_BITS;
              sda_low <= ~wdata[7];
            end
          end else if (launch_rd) begin
            cur_rd    <= 1'b1;
            addr_byte <= 1'b0;
            st        <= S_BITS;
            sda_low   <= 1'b0;
          end else if (launch_stop) begin
            if (scl_low) begin
              st      <= S_STOP;
              sda_low <= 1'b1;
            end else begin
              stop_req <= 1'b0;
            end
          end
        end
        S_START: if (tick) begin
          case (qtr)
            2'd0: scl_low <= 1'b0;
            2'd1: sda_low <= 1'b1;
            2'd2: scl_low <= 1'b1;
            default: begin
              start_req <= 1'b0;
              sda_low   <= sda_for(4'd0, cur_rd, lastrd, tx_sh);
              bitn      <= 4'd0;
              st        <= S_BITS;
            end
          endcase
        end
        S_BITS: if (tick) begin
          case (qtr)
            2'd0: scl_low <= 1'b0;
            2'd1: begin
              if (cur_rd && bitn < 4'd8) rx_sh <= {rx_sh[6:0], sda_in};
              if (bitn == 4'd8) ack <= ~sda_in;
              if (owns_bit && (sda_in == sda_low)) berr <= 1'b1;
            end
            2'd2: scl_low <= 1'b1;
            default: begin
              if (bitn == 4'd8) begin
                done <= 1'b1;
                st   <= S_IDLE;
                if (addr_byte) rd_mode <= tx_sh[0];
                if (cur_rd && lastrd) rd_mode <= 1'b0;
              end else begin
                bitn    <= bitn + 4'd1;
                sda_low <= sda_for(bitn + 4'd1, cur_rd, lastrd, tx_sh);
              end
            end
          endcase
        end
        S_STOP: if (tick) begin
          case (qtr)
            2'd0: scl_low <= 1'b0;
            2'd1: sda_low <= 1'b0;
            2'd2: ;
            default: begin
              stop_req <= 1'b0;
              rd_mode  <= 1'b0;
              st       <= S_IDLE;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: SDA may fall under a high SCL only while a start condition is driven
  a_r2_start_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low && $past(!scl_low) && $rose(sda_low)) |-> st == S_START);

  // R8: SDA may rise under a high SCL only while a stop condition is driven
  a_r8_stop_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low && $past(!scl_low) && $fell(sda_low)) |-> st == S_STOP);

  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_req) |-> (!scl_low && !sda_low));

  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r5_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && st == S_IDLE) |=> !done);

  a_r10_no_launch_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && stop_req) |=> (st != S_BITS && st != S_START));

  a_r11_idle_scl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) == S_IDLE) |-> $stable(scl_low));
endmodule

// File: tb/tb_i2c_byte_master.sv
`timescale 1ns/1ps
module tb_i2c_byte_master;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 4;
  localparam logic [6:0] SLV = 7'h50;
  // {addr7, ack expected, data0, data1}
  localparam logic [23:0] VEC [4] = '{
    {7'h50, 1'b1, 8'hA5, 8'h3C},
    {7'h50, 1'b1, 8'h00, 8'hFF},
    {7'h23, 1'b0, 8'h00, 8'h00},
    {7'h50, 1'b1, 8'h81, 8'h7E}
  };

  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq, scl_pull, sda_pull;
  logic s_low = 0, s_force = 0;
  wire scl_line = ~scl_pull;
  wire sda_line = ~(sda_pull | s_low | s_force);

  int checks = 0, errors = 0, cyc = 0, irq_cnt = 0;
  int hc = 0, last_high = 0, scl_falls = 0;

  i2c_byte_master #(.QTR_CLKS(QTR)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .wdata(wdata), .rdata(rdata), .irq(irq), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .sda_in(sda_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (irq) irq_cnt++;
    if (scl_line) hc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
  always @(negedge scl_line) begin last_high = hc; hc = 0; scl_falls++; end

  // behavioural target
  int st = 0, bc = 0, ridx = 0, starts = 0, stops = 0, wn = 0, rcount = 0;
  logic [7:0] sh = 0, tx = 0, last_addr = 0;
  logic mnak = 0;
  logic [7:0] wlog [32];
  logic mack [32];

  function automatic logic [7:0] mem(input int i);
    return 8'h3C + 8'(i * 8'h11);
  endfunction

  always @(negedge sda_line) if (scl_line) begin
    starts++; st = 1; bc = -1; s_low = 0; ridx = 0;
  end
  always @(posedge sda_line) if (scl_line) begin
    stops++; st = 0; s_low = 0;
  end
  always @(posedge scl_line) begin
    if ((st == 1 || st == 2) && bc >= 0 && bc < 8) sh = {sh[6:0], sda_line};
    else if (st == 3 && bc == 8) mnak = sda_line;
  end
  always @(negedge scl_line) if (st != 0) begin
    bc++;
    if (st == 1 || st == 2) begin
      if (bc == 8) begin
        if (st == 1) begin last_addr = sh; if (sh[7:1] == SLV) s_low = 1; end
        else begin wlog[wn % 32] = sh; wn++; s_low = 1; end
      end else if (bc == 9) begin
        s_low = 0; bc = 0;
        if (st == 1) begin
          if (last_addr[7:1] != SLV) st = 0;
          else if (last_addr[0]) begin st = 3; tx = mem(ridx); s_low = ~tx[7]; end
          else st = 2;
        end
      end
    end else begin
      if (bc < 8) s_low = ~tx[7 - bc];
      else if (bc == 8) s_low = 0;
      else begin
        bc = 0; mack[rcount % 32] = mnak; rcount++;
        if (mnak) begin st = 0; s_low = 0; end
        else begin ridx++; tx = mem(ridx); s_low = ~tx[7]; end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_sel = sel; wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk); reg_sel = sel; reg_rd = 1; #1 d = rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_bit(input int b, input logic val, input string tag);
    logic [7:0] s;
    int n = 0;
    do begin rd(0, s); n++; end while (s[b] !== val && n < 3000);
    if (s[b] !== val) chk(tag, s[b], val);
  endtask

  initial begin
    logic [7:0] s, d;
    int s0, w0, i0, p0, f0;
    #(CLK_PERIOD * 3) rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 scl released", scl_line, 1);
    chk("R1 sda released", sda_line, 1);
    chk("R1 irq low", irq, 0);
    rd(0, s); chk("R1 status", s, 8'h00);

    for (int i = 0; i < 4; i++) begin
      logic [23:0] v;
      v = VEC[i];
      s0 = starts; w0 = wn; i0 = irq_cnt;
      wr(0, 8'h80); wr(1, {v[23:17], 1'b0});
      wait_bit(0, 1, "R3 done timeout");
      rd(0, s);
      chk("R2 one start", starts - s0, 1);
      chk("R2 address msb first", last_addr, {v[23:17], 1'b0});
      chk("R3 ack bit", s[1], v[16]);
      chk("R3 done set", s[0], 1);
      chk("R9 no berr", s[2], 0);
      chk("R4 irq per byte", irq_cnt - i0, 1);
      if (v[16]) begin
        wr(1, v[15:8]); wait_bit(0, 1, "R6 done timeout");
        wr(1, v[7:0]);  wait_bit(0, 1, "R6 done timeout");
        chk("R6 byte0", wlog[w0 % 32], v[15:8]);
        chk("R6 byte1", wlog[(w0 + 1) % 32], v[7:0]);
        chk("R6 no extra start", starts - s0, 1);
        chk("R4 irq count", irq_cnt - i0, 3);
        chk("R11 scl high width", last_high, 2 * QTR);
      end
      p0 = stops;
      wr(0, 8'h40); rd(0, s);
      chk("R8 stop flag held", s[6], 1);
      wait_bit(6, 0, "R8 stop timeout");
      chk("R8 stop seen", stops - p0, 1);
      chk("R8 scl released", scl_line, 1);
      chk("R8 sda released", sda_line, 1);
    end

    // R12 repeated start, then R7 read with last-read NAK
    s0 = starts; p0 = stops; w0 = wn;
    wr(0, 8'h80); wr(1, {SLV, 1'b0}); wait_bit(0, 1, "R12 done timeout");
    wr(1, 8'h11); wait_bit(0, 1, "R12 done timeout");
    chk("R12 write before restart", wlog[w0 % 32], 8'h11);
    wr(0, 8'h80); wr(1, {SLV, 1'b1}); wait_bit(0, 1, "R12 done timeout");
    rd(0, s);
    chk("R12 two starts", starts - s0, 2);
    chk("R12 no stop between", stops - p0, 0);
    chk("R12 read address acked", s[1], 1);
    i0 = rcount;
    rd(1, d); wait_bit(0, 1, "R7 done timeout");
    rd(1, d); chk("R7 byte0", d, mem(0));
    rd(0, s); chk("R5 done cleared by data read", s[0], 0);
    wait_bit(0, 1, "R7 done timeout");
    wr(0, 8'h20);
    rd(1, d); chk("R7 byte1", d, mem(1));
    wait_bit(0, 1, "R7 done timeout");
    chk("R7 byte0 acked", mack[i0 % 32], 0);
    chk("R7 byte1 acked", mack[(i0 + 1) % 32], 0);
    chk("R7 final byte nak", mack[(i0 + 2) % 32], 1);
    f0 = scl_falls;
    rd(1, d); chk("R7 byte2", d, mem(2));
    repeat (200) @(negedge clk);
    chk("R7 no reception after nak", scl_falls - f0, 0);
    rd(0, s); chk("R7 done stays clear", s[0], 0);
    wr(0, 8'h40); wait_bit(6, 0, "R8 stop timeout");

    // R10 writes while busy or with stop pending are ignored
    wr(0, 8'h80); wr(1, {SLV, 1'b0}); wait_bit(0, 1, "R10 done timeout");
    w0 = wn; i0 = irq_cnt;
    wr(1, 8'h55); wr(1, 8'h66);
    wait_bit(0, 1, "R10 done timeout");
    wr(0, 8'h40); wr(1, 8'h99);
    wait_bit(6, 0, "R10 stop timeout");
    repeat (200) @(negedge clk);
    chk("R10 busy write dropped", wn - w0, 1);
    chk("R10 sent byte", wlog[w0 % 32], 8'h55);
    chk("R10 irq count", irq_cnt - i0, 1);

    // R9 bus error on contention, cleared by start
    s_force = 1;
    wr(0, 8'h80); wr(1, 8'hA0); wait_bit(0, 1, "R9 done timeout");
    rd(0, s); chk("R9 berr set", s[2], 1);
    s_force = 0;
    wr(0, 8'h40); wait_bit(6, 0, "R9 stop timeout");
    rd(0, s); chk("R9 berr sticky", s[2], 1);
    wr(0, 8'h80); rd(0, s); chk("R9 berr cleared by start", s[2], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule